// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers eight interrupt request lines and turns them into a single interrupt output toward a processor. A rising edge on a request line sets a pending bit. The pending bit then passes through a mask, and a fixed-priority resolver weighs it against the interrupts already being serviced. When a request wins, the interrupt output is raised.

The processor answers with two active-low acknowledge pulses. On the first pulse the winning request moves from pending to in-service. During the second pulse the block places the programmed vector byte on the data bus. From the first pulse until the end of the second, new edges on the request lines are ignored.

Software programs the block through a write port with a single address bit. The setup sequence is a start word at address 0, then the vector byte at address 1, then an optional mode word at address 1. After setup, writes at address 1 load the mask and command writes at address 0 end interrupts. A mode bit chooses how the in-service bit is released: automatically at the end of the second pulse, or by an explicit command. Two read addresses expose the in-service set and the mask.

Top module: `vic_core`

## Requirements
- R1: After reset, `int_out` and `data_oe` are 0. `int_out` stays 0 until setup has finished, whatever the request lines do.
- R2: Setup begins with a write at address 0 whose bit 4 is 1. Bit 0 of that write says whether a mode word follows. The next write at address 1 is the vector byte. If a mode word was announced, the following address-1 write is the mode word, and its bit 1 selects automatic release. If no mode word was announced, automatic release is off and the next address-1 write already loads the mask.
- R3: A 0-to-1 transition on request line i sets pending bit i. A mask bit of 1 keeps that request from raising `int_out`, and a mask bit of 0 lets it through.
- R4: Line 0 has the highest priority and line 7 the lowest. A pending, unmasked request raises `int_out` only when no in-service bit at its own or a higher priority is set.
- R5: On the first acknowledge pulse, the in-service bit of the winning request is set and its pending bit is cleared. `int_out` is 0 from the first pulse until the handshake ends.
- R6: While the second acknowledge pulse is low, `data_oe` is 1 and `data_out` carries the vector byte. Apart from reads, `data_oe` is 0 at all other times.
- R7: Rising edges on request lines that arrive between the start of the first pulse and the end of the second pulse are lost. They never raise `int_out`.
- R8: With automatic release on, the in-service bit set by the first pulse is cleared when the second pulse ends.
- R9: A write at address 0 with bit 4 = 0, bit 3 = 0 and bit 5 = 1 clears the highest-priority in-service bit that is set.
- R10: Holding `rd_en` for one cycle makes `data_oe` 1 for one cycle, starting one cycle later. `data_out` then carries the in-service set when `addr` is 0, or the mask when `addr` is 1.
- R11: A setup start word clears the mask, all pending bits and all in-service bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, synchronous to clk |
| ack_n | input | 1 | Active-low acknowledge from the processor |
| wr_en | input | 1 | One-cycle register write strobe |
| rd_en | input | 1 | One-cycle register read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| data_out | output | 8 | Read data or vector byte |
| data_oe | output | 1 | Output enable for the data bus driver |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The properties take several things for granted about the inputs:
- Acknowledge pulses arrive as complete pairs, each low and high phase lasting at least one clock.
- No read, write or setup word overlaps a handshake.
- Every input is already synchronous to `clk`.

The stimulus keeps to these limits. Each handshake runs inside one task, with two-cycle low and high phases. Register accesses run only between handshakes, and request lines change only on the falling clock edge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {ACK_IDLE, ACK_FIRST, ACK_GAP, ACK_SECOND} ack_phase_e;
  typedef enum logic [1:0] {CFG_OFF, CFG_VEC, CFG_MODE, CFG_RUN} cfg_state_e;

  // bit positions inside words written at address 0 / mode word
  localparam int unsigned CMD_INIT_BIT  = 4;
  localparam int unsigned CMD_SEL_BIT   = 3;
  localparam int unsigned CMD_EOI_BIT   = 5;
  localparam int unsigned NEED_MODE_BIT = 0;
  localparam int unsigned AEOI_BIT      = 1;
endpackage

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] isr,
  output logic [N-1:0] grant_oh,
  output logic         grant_valid,
  output logic [N-1:0] isr_top_oh
);
  logic [N-1:0] pend;
  logic [N:0]   req_seen;
  logic [N:0]   isr_seen;

  assign pend        = req & ~mask;
  assign req_seen[0] = 1'b0;
  assign isr_seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign req_seen[g+1] = req_seen[g] | pend[g];
    assign isr_seen[g+1] = isr_seen[g] | isr[g];
    // first pending line, and only if nothing in service at same or higher level
    assign grant_oh[g]   = pend[g] & ~req_seen[g] & ~isr_seen[g+1];
    assign isr_top_oh[g] = isr[g] & ~isr_seen[g];
  end

  assign grant_valid = |grant_oh;
endmodule

// File: rtl/vic_cfg.sv
module vic_cfg import vic_pkg::*; #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] vector,
  output logic [N-1:0]  mask,
  output logic          aeoi,
  output logic          init_hit,
  output logic          eoi_hit
);
  cfg_state_e st;
  logic       need_mode;

  assign ready    = (st == CFG_RUN);
  assign init_hit = wr_en & ~addr & wdata[CMD_INIT_BIT];
  assign eoi_hit  = wr_en & ~addr & ~wdata[CMD_INIT_BIT] & ~wdata[CMD_SEL_BIT]
                  & wdata[CMD_EOI_BIT] & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CFG_OFF;
      need_mode <= 1'b0;
      vector    <= '0;
      mask      <= '0;
      aeoi      <= 1'b0;
    end else if (init_hit) begin
      st        <= CFG_VEC;
      need_mode <= wdata[NEED_MODE_BIT];
      mask      <= '0;
      aeoi      <= 1'b0;
    end else if (wr_en && addr) begin
      case (st)
        CFG_VEC: begin
          vector <= wdata;
          st     <= need_mode ? CFG_MODE : CFG_RUN;
        end
        CFG_MODE: begin
          aeoi <= wdata[AEOI_BIT];
          st   <= CFG_RUN;
        end
        CFG_RUN: mask <= wdata[N-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vic_ack.sv
module vic_ack import vic_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  output logic first_start,
  output logic second_on,
  output logic second_end,
  output logic frozen
);
  ack_phase_e phase;
  logic       ack_q;
  logic       fall;
  logic       rise;

  assign fall        = ack_q & ~ack_n;
  assign rise        = ~ack_q & ack_n;
  assign first_start = (phase == ACK_IDLE) & fall;
  assign second_on   = ((phase == ACK_GAP) & fall) | ((phase == ACK_SECOND) & ~rise);
  assign second_end  = (phase == ACK_SECOND) & rise;
  assign frozen      = (phase != ACK_IDLE) | first_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b1;
      phase <= ACK_IDLE;
    end else begin
      ack_q <= ack_n;
      case (phase)
        ACK_IDLE:   if (fall) phase <= ACK_FIRST;
        ACK_FIRST:  if (rise) phase <= ACK_GAP;
        ACK_GAP:    if (fall) phase <= ACK_SECOND;
        ACK_SECOND: if (rise) phase <= ACK_IDLE;
        default:    phase <= ACK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vic_core.sv
module vic_core #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          ack_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          int_out
);
  logic          cfg_ready, cfg_aeoi, cfg_init, cfg_eoi;
  logic [DW-1:0] cfg_vector;
  logic [N-1:0]  cfg_mask;
  logic          first_start, second_on, second_end, frozen;
  logic [N-1:0]  grant_raw, grant_oh, isr_top;
  logic          grant_any;
  logic [N-1:0]  irq_q, irr_q, isr_q, act_q;
  logic [N-1:0]  irr_nxt, isr_nxt;

  vic_cfg #(.N(N), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ready(cfg_ready), .vector(cfg_vector), .mask(cfg_mask), .aeoi(cfg_aeoi),
    .init_hit(cfg_init), .eoi_hit(cfg_eoi)
  );

  vic_ack u_ack (
    .clk(clk), .rst(rst), .ack_n(ack_n), .first_start(first_start),
    .second_on(second_on), .second_end(second_end), .frozen(frozen)
  );

  vic_prio #(.N(N)) u_prio (
    .req(irr_q), .mask(cfg_mask), .isr(isr_q),
    .grant_oh(grant_raw), .grant_valid(grant_any), .isr_top_oh(isr_top)
  );

  assign grant_oh = cfg_ready ? grant_raw : '0;

  always_comb begin
    irr_nxt = irr_q;
    if (!frozen)     irr_nxt = irr_q | (irq_in & ~irq_q);
    if (first_start) irr_nxt = irr_nxt & ~grant_oh;
    if (cfg_init)    irr_nxt = '0;
  end

  always_comb begin
    isr_nxt = isr_q;
    if (first_start)             isr_nxt = isr_nxt | grant_oh;
    if (second_end && cfg_aeoi)  isr_nxt = isr_nxt & ~act_q;
    if (cfg_eoi)                 isr_nxt = isr_nxt & ~isr_top;
    if (cfg_init)                isr_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q    <= '0;
      irr_q    <= '0;
      isr_q    <= '0;
      act_q    <= '0;
      int_out  <= 1'b0;
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      irq_q   <= irq_in;
      irr_q   <= irr_nxt;
      isr_q   <= isr_nxt;
      if (first_start) act_q <= grant_oh;
      int_out <= cfg_ready & ~frozen & grant_any;
      data_oe <= second_on | rd_en;
      if (second_on)  data_out <= cfg_vector;
      else if (rd_en) data_out <= addr ? DW'(cfg_mask) : DW'(isr_q);
    end
  end
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ack_n,
  input logic          rd_en,
  input logic          int_out,
  input logic          data_oe,
  input logic [DW-1:0] data_out,
  input logic [DW-1:0] vector,
  input logic          ready,
  input logic          eoi_hit,
  input logic          aeoi,
  input logic [N-1:0]  isr
);
  p_quiet_unready_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(ready) |-> !int_out);

  p_quiet_in_ack_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(ack_n) |-> !int_out);

  p_one_grant_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(isr) <= $countones($past(isr)) + 1);

  p_oe_source_r6: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ($past(rd_en) || !$past(ack_n)));

  p_vector_r6: assert property (@(posedge clk) disable iff (rst)
    (data_oe && !$past(rd_en)) |-> (data_out == vector));

  p_eoi_clears_one_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(eoi_hit) && $past(ack_n) && !$past(aeoi) && ($past(isr) != '0))
      |-> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

bind vic_core vic_core_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ack_n(ack_n), .rd_en(rd_en), .int_out(int_out),
  .data_oe(data_oe), .data_out(data_out), .vector(cfg_vector),
  .ready(cfg_ready), .eoi_hit(cfg_eoi), .aeoi(cfg_aeoi), .isr(isr_q)
);

// File: tb/vic_core_test.sv
module vic_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       ack_n = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] data_out;
  logic       data_oe;
  logic       int_out;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       prev_oe = 1'b0;

  always #10 clk = ~clk;

  vic_core uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .ack_n(ack_n), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .data_out(data_out),
    .data_oe(data_oe), .int_out(int_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: each rise of data_oe pops one expected byte
  always @(negedge clk) begin
    if (data_oe && !prev_oe && !rst) begin
      if (exp_q.size() == 0) check("R6 unexpected drive", 8'h01, 8'h00);
      else check(tag_q.pop_front(), data_out, exp_q.pop_front());
    end
    prev_oe <= data_oe;
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic int_is(input logic exp, input string tag);
    repeat (3) @(negedge clk);
    check(tag, {7'd0, int_out}, {7'd0, exp});
  endtask

  task automatic ack_seq(input logic [7:0] vec, input logic [7:0] late);
    exp_q.push_back(vec); tag_q.push_back("R6 vector byte");
    @(negedge clk); ack_n = 1'b0; irq_in = irq_in | late;
    @(negedge clk); check("R5 int low in handshake", {7'd0, int_out}, 8'h00);
    @(negedge clk); ack_n = 1'b1;
    repeat (2) @(negedge clk); ack_n = 1'b0;
    repeat (2) @(negedge clk); ack_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset int", {7'd0, int_out}, 8'h00);
    check("R1 reset oe", {7'd0, data_oe}, 8'h00);
    irq_in = 8'h01;
    int_is(1'b0, "R1 no int before setup");
    irq_in = 8'h00;

    // setup with mode word, command-driven release
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
    rd(1'b1, 8'h00, "R10 mask read");

    irq_in = 8'h08;
    int_is(1'b1, "R3 edge raises int");
    ack_seq(8'h40, 8'h00);
    rd(1'b0, 8'h08, "R5 in-service set");
    int_is(1'b0, "R5 pending cleared");

    irq_in = 8'h28;
    int_is(1'b0, "R4 lower blocked by in-service");
    irq_in = 8'h2A;
    int_is(1'b1, "R4 higher preempts");
    ack_seq(8'h40, 8'h00);
    rd(1'b0, 8'h0A, "R5 nested in-service");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h08, "R9 top bit cleared");
    int_is(1'b0, "R4 line5 still blocked");
    wr(1'b0, 8'h20);
    int_is(1'b1, "R4 line5 released");
    ack_seq(8'h40, 8'h00);
    rd(1'b0, 8'h20, "R5 line5 in service");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h00, "R9 all cleared");
    irq_in = 8'h00;

    wr(1'b1, 8'h04);
    rd(1'b1, 8'h04, "R10 mask readback");
    irq_in = 8'h04;
    int_is(1'b0, "R3 masked line");
    wr(1'b1, 8'h00);
    int_is(1'b1, "R3 unmasked line");
    ack_seq(8'h40, 8'h00);
    wr(1'b0, 8'h20);
    irq_in = 8'h00;

    // edge during handshake is lost
    irq_in = 8'h10;
    int_is(1'b1, "R3 line4");
    ack_seq(8'h40, 8'h40);
    rd(1'b0, 8'h10, "R7 only line4 served");
    wr(1'b0, 8'h20);
    int_is(1'b0, "R7 frozen edge lost");
    irq_in = 8'h00;

    // restart clears state
    wr(1'b1, 8'hF0);
    irq_in = 8'h01;
    int_is(1'b1, "R3 line0");
    ack_seq(8'h40, 8'h00);
    wr(1'b0, 8'h11); wr(1'b1, 8'h88); wr(1'b1, 8'h02);
    rd(1'b0, 8'h00, "R11 in-service cleared");
    rd(1'b1, 8'h00, "R11 mask cleared");
    int_is(1'b0, "R11 pending cleared");
    irq_in = 8'h00;
    @(negedge clk);
    irq_in = 8'h80;
    int_is(1'b1, "R8 line7");
    ack_seq(8'h88, 8'h00);
    rd(1'b0, 8'h00, "R8 auto release");

    // setup without mode word
    irq_in = 8'h00;
    wr(1'b0, 8'h10);
    irq_in = 8'h08;
    int_is(1'b0, "R1 mid-setup quiet");
    irq_in = 8'h00;
    wr(1'b1, 8'h55);
    wr(1'b1, 8'h80);
    rd(1'b1, 8'h80, "R2 next write is mask");
    irq_in = 8'h08;
    int_is(1'b1, "R2 ready after two words");
    ack_seq(8'h55, 8'h00);
    rd(1'b0, 8'h08, "R2 release off by default");

    repeat (4) @(negedge clk);
    check("R6 all expected bytes seen", 8'(exp_q.size()), 8'h00);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule